// File: doc/BRIEF.md
# Line Wake-Up Detector and Generator

This block watches a single-wire industrial signalling line for a wake-up request and, when acting as the line master, produces one. In device use it compares the sampled receive level with the level its own driver is set to. A disagreement that lasts long enough is a wake-up. The block then gives a fixed-length active-low pulse and latches an interrupt flag. Detection is blanked for a selectable time after every driver level change, so that slow charging of a capacitive or lamp load is not mistaken for a wake-up.

In master use, a generate strobe starts a four-phase sequence. The phases are:
- capture the idle line level;
- drive the opposite level;
- drive the captured level again;
- float the line.

While the sequence runs, the block ignores the transmit pins and raises override outputs that force a high current limit and the fastest slew rate. The stored configuration is left untouched. All durations are parameters in clock cycles.

Top module: `wake_line_ctrl`

## Requirements
- R1: After reset, wake_n is 1 and wake_flag, irq, gen_busy and all five override outputs are 0.
- R2: With drv_en = 1 and line_rx different from drv_level for DET_CYC consecutive clock samples, none of which is blanked, wake_n goes low in the cycle after the DET_CYC-th sample. A shorter mismatch has no effect. An unbroken mismatch produces only one event.
- R3: Each wake-up event holds wake_n low for exactly PULSE_CYC cycles, after which it returns high.
- R4: While detect_off = 1, mismatch samples are not counted: no pulse appears and wake_flag is not set.
- R5: A wake-up event sets wake_flag, which stays 1 until an int_read strobe clears it one cycle later (a simultaneous event wins). irq is 1 exactly when wake_flag = 1 and wake_mask = 0.
- R6: In the cycle in which drv_level differs from its previous value, and in the next BLANKn cycles, mismatch samples are not counted. n is blank_sel: 0 to 3 pick BLANK0 to BLANK3.
- R7: A generation sequence starts only on a gen_start strobe while tx_en_pin = 0, tx_pin = 1 and no sequence is running. Otherwise the strobe is ignored.
- R8: A started sequence runs through four phases. First, for GEN_CYC cycles, ovr_en = 1 and ovr_level is the inverse of line_rx sampled at the start. Next, for ON_CYC cycles, ovr_en = 1 and ovr_level is the sampled level. Then, for HIZ_CYC cycles, ovr_hiz = 1 and ovr_en = 0. Finally the block returns to idle. gen_busy is 1 for exactly these cycles. tx_pin and tx_en_pin have no effect on the sequence.
- R9: ovr_boost_ilim and ovr_fast_slew are 1 in every busy cycle and 0 otherwise.
- R10: Mismatch samples taken while gen_busy = 1 are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_rx | input | 1 | Sampled receive level of the line |
| drv_level | input | 1 | Level the driver is set to |
| drv_en | input | 1 | Driver enabled |
| tx_en_pin | input | 1 | Transmit-enable pin |
| tx_pin | input | 1 | Transmit data pin |
| detect_off | input | 1 | Disables wake-up detection |
| gen_start | input | 1 | One-cycle strobe requesting generation |
| wake_mask | input | 1 | Masks the wake-up interrupt |
| int_read | input | 1 | One-cycle interrupt-read strobe, clears wake_flag |
| blank_sel | input | 2 | Selects blanking length BLANK0..BLANK3 |
| wake_n | output | 1 | Active-low wake-up pulse |
| wake_flag | output | 1 | Latched wake-up interrupt bit |
| irq | output | 1 | Unmasked interrupt request |
| ovr_en | output | 1 | Forces the driver on |
| ovr_level | output | 1 | Level forced while ovr_en is 1 |
| ovr_hiz | output | 1 | Forces the driver to high impedance |
| ovr_boost_ilim | output | 1 | Forces the high current limit |
| ovr_fast_slew | output | 1 | Forces the fastest slew rate |
| gen_busy | output | 1 | Generation sequence running |

## Verification
The assertions assume that gen_start and int_read are single-cycle strobes. They also assume that every duration parameter is at least one cycle, and that PULSE_CYC exceeds the longest possible retrigger gap. The bench holds every strobe high for exactly one cycle and uses small duration values. It changes inputs only on the falling clock edge, so each level is sampled whole. Mismatch windows are always placed either well short of or well beyond DET_CYC, so no sample lands ambiguously on a blanking or busy boundary.

// File: rtl/wake_line_ctrl.sv
module wake_line_ctrl #(
  parameter int DET_CYC   = 800,
  parameter int PULSE_CYC = 2000,
  parameter int GEN_CYC   = 800,
  parameter int ON_CYC    = 500,
  parameter int HIZ_CYC   = 1000,
  parameter int BLANK0    = 500,
  parameter int BLANK1    = 1000,
  parameter int BLANK2    = 2000,
  parameter int BLANK3    = 5000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_rx,
  input  logic       drv_level,
  input  logic       drv_en,
  input  logic       tx_en_pin,
  input  logic       tx_pin,
  input  logic       detect_off,
  input  logic       gen_start,
  input  logic       wake_mask,
  input  logic       int_read,
  input  logic [1:0] blank_sel,
  output logic       wake_n,
  output logic       wake_flag,
  output logic       irq,
  output logic       ovr_en,
  output logic       ovr_level,
  output logic       ovr_hiz,
  output logic       ovr_boost_ilim,
  output logic       ovr_fast_slew,
  output logic       gen_busy
);

  localparam int BMAX01 = (BLANK0 > BLANK1) ? BLANK0 : BLANK1;
  localparam int BMAX23 = (BLANK2 > BLANK3) ? BLANK2 : BLANK3;
  localparam int BMAX   = (BMAX01 > BMAX23) ? BMAX01 : BMAX23;
  localparam int GMAX0  = (GEN_CYC > ON_CYC) ? GEN_CYC : ON_CYC;
  localparam int GMAX   = (GMAX0 > HIZ_CYC) ? GMAX0 : HIZ_CYC;
  localparam int DW = $clog2(DET_CYC + 1);
  localparam int PW = $clog2(PULSE_CYC + 1);
  localparam int BW = $clog2(BMAX + 1);
  localparam int GW = $clog2(GMAX + 1);

  typedef enum logic [1:0] {G_IDLE, G_OPP, G_BACK, G_HIZ} gstate_t;

  gstate_t         gst;
  logic [GW-1:0]   gcnt;
  logic            orig_q;
  logic [DW-1:0]   dcnt;
  logic [PW-1:0]   pcnt;
  logic [BW-1:0]   bcnt;
  logic [BW-1:0]   blank_len;
  logic            lvl_q;
  logic            trans, blanked, mismatch, qual, fire, start;

  always_comb begin
    case (blank_sel)
      2'd0:    blank_len = BW'(BLANK0);
      2'd1:    blank_len = BW'(BLANK1);
      2'd2:    blank_len = BW'(BLANK2);
      default: blank_len = BW'(BLANK3);
    endcase
  end

  assign gen_busy = (gst != G_IDLE);
  assign trans    = (drv_level != lvl_q);
  assign blanked  = trans || (bcnt != '0);
  assign mismatch = drv_en && (line_rx != drv_level);
  assign qual     = mismatch && !blanked && !detect_off && !gen_busy;
  assign fire     = qual && (dcnt == DW'(DET_CYC - 1));
  assign start    = gen_start && !tx_en_pin && tx_pin && !gen_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      bcnt  <= '0;
    end else begin
      lvl_q <= drv_level;
      if (trans)
        bcnt <= blank_len;
      else if (bcnt != '0)
        bcnt <= bcnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      dcnt <= '0;
    else if (!qual)
      dcnt <= '0;
    else if (dcnt != DW'(DET_CYC))
      dcnt <= dcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pcnt <= '0;
    else if (fire)
      pcnt <= PW'(PULSE_CYC);
    else if (pcnt != '0)
      pcnt <= pcnt - 1'b1;
  end

  assign wake_n = (pcnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      wake_flag <= 1'b0;
    else if (fire)
      wake_flag <= 1'b1;
    else if (int_read)
      wake_flag <= 1'b0;
  end

  assign irq = wake_flag && !wake_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gst    <= G_IDLE;
      gcnt   <= '0;
      orig_q <= 1'b0;
    end else begin
      case (gst)
        G_IDLE: if (start) begin
          gst    <= G_OPP;
          gcnt   <= GW'(GEN_CYC - 1);
          orig_q <= line_rx;
        end
        G_OPP: if (gcnt == '0) begin
          gst  <= G_BACK;
          gcnt <= GW'(ON_CYC - 1);
        end else gcnt <= gcnt - 1'b1;
        G_BACK: if (gcnt == '0) begin
          gst  <= G_HIZ;
          gcnt <= GW'(HIZ_CYC - 1);
        end else gcnt <= gcnt - 1'b1;
        default: if (gcnt == '0) gst <= G_IDLE;
                 else gcnt <= gcnt - 1'b1;
      endcase
    end
  end

  assign ovr_en         = (gst == G_OPP) || (gst == G_BACK);
  assign ovr_level      = (gst == G_OPP) ? !orig_q : ((gst == G_BACK) && orig_q);
  assign ovr_hiz        = (gst == G_HIZ);
  assign ovr_boost_ilim = gen_busy;
  assign ovr_fast_slew  = gen_busy;

endmodule

// File: rtl/wake_line_ctrl_chk.sv
module wake_line_ctrl_chk #(
  parameter int PULSE_CYC = 2000
) (
  input logic clk,
  input logic rst_n,
  input logic line_rx,
  input logic tx_en_pin,
  input logic tx_pin,
  input logic detect_off,
  input logic gen_start,
  input logic wake_n,
  input logic wake_flag,
  input logic ovr_en,
  input logic ovr_level,
  input logic ovr_hiz,
  input logic ovr_boost_ilim,
  input logic gen_busy
);
  int lowrun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lowrun <= 0;
    else if (!wake_n) lowrun <= (lowrun < PULSE_CYC + 1) ? lowrun + 1 : lowrun;
    else lowrun <= 0;
  end

  assert_pulse_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_n) |-> lowrun >= PULSE_CYC);

  assert_flag_with_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_flag) |-> !wake_n);

  assert_detect_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    detect_off |=> !$rose(wake_flag));

  assert_busy_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    gen_busy |=> !$rose(wake_flag));

  assert_start_cond_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gen_busy) |-> $past(gen_start && !tx_en_pin && tx_pin));

  assert_first_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gen_busy) |-> ovr_en && (ovr_level != $past(line_rx)));

  assert_ends_in_hiz_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gen_busy) |-> $past(ovr_hiz) && !ovr_hiz);

  assert_boost_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gen_busy) |-> !ovr_boost_ilim);
endmodule

bind wake_line_ctrl wake_line_ctrl_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_rx(line_rx), .tx_en_pin(tx_en_pin),
  .tx_pin(tx_pin), .detect_off(detect_off), .gen_start(gen_start),
  .wake_n(wake_n), .wake_flag(wake_flag), .ovr_en(ovr_en),
  .ovr_level(ovr_level), .ovr_hiz(ovr_hiz), .ovr_boost_ilim(ovr_boost_ilim),
  .gen_busy(gen_busy)
);

// File: tb/wake_line_ctrl_test.sv
`timescale 1ns/1ps
module wake_line_ctrl_test;
  localparam int DET = 8, PUL = 20, GEN = 6, ON = 4, HIZ = 5;
  localparam int B0 = 3, B1 = 6, B2 = 9, B3 = 12;
  localparam logic [8:0] ALL = 9'h1FF, WK = 9'h180, WKI = 9'h1C0, OVR = 9'h03F;

  logic clk = 0, rst_n = 0;
  logic line_rx = 0, drv_level = 0, drv_en = 0, tx_en_pin = 0, tx_pin = 0;
  logic detect_off = 0, gen_start = 0, wake_mask = 0, int_read = 0;
  logic [1:0] blank_sel = 0;
  logic wake_n, wake_flag, irq, ovr_en, ovr_level, ovr_hiz, ovr_boost_ilim, ovr_fast_slew, gen_busy;

  wake_line_ctrl #(.DET_CYC(DET), .PULSE_CYC(PUL), .GEN_CYC(GEN), .ON_CYC(ON),
    .HIZ_CYC(HIZ), .BLANK0(B0), .BLANK1(B1), .BLANK2(B2), .BLANK3(B3)) uut (
    .clk(clk), .rst_n(rst_n), .line_rx(line_rx), .drv_level(drv_level), .drv_en(drv_en),
    .tx_en_pin(tx_en_pin), .tx_pin(tx_pin), .detect_off(detect_off), .gen_start(gen_start),
    .wake_mask(wake_mask), .int_read(int_read), .blank_sel(blank_sel), .wake_n(wake_n),
    .wake_flag(wake_flag), .irq(irq), .ovr_en(ovr_en), .ovr_level(ovr_level),
    .ovr_hiz(ovr_hiz), .ovr_boost_ilim(ovr_boost_ilim), .ovr_fast_slew(ovr_fast_slew),
    .gen_busy(gen_busy));

  always #2.5 clk = ~clk;

  typedef struct { int cyc; logic [8:0] exp; logic [8:0] care; string tag; } item_t;
  item_t sb[$];
  int cyc = 0, checks = 0, errors = 0;
  bit done = 0;
  logic [8:0] obs;
  assign obs = {wake_n, wake_flag, irq, ovr_en, ovr_level, ovr_hiz, ovr_boost_ilim, ovr_fast_slew, gen_busy};

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(int c, logic [8:0] e, logic [8:0] m, string t);
    item_t it;
    it.cyc = c; it.exp = e; it.care = m; it.tag = t;
    sb.push_back(it);
  endtask

  always @(negedge clk) begin
    #1;
    while (sb.size() > 0 && sb[0].cyc <= cyc) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (it.cyc < cyc || ((obs ^ it.exp) & it.care) != 0) begin
        errors++;
        $display("FAIL %s cyc=%0d actual=%b expected=%b care=%b", it.tag, cyc, obs, it.exp, it.care);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    while (sb.size() > 0) @(negedge clk);
    step(1);
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    step(3);
    rst_n = 1;
    expect_at(cyc, 9'h100, ALL, "R1 reset state");
    expect_at(cyc + 1, 9'h100, ALL, "R1 reset state held");
    drain();

    // R2/R3/R5: detection, pulse length, single event, irq
    drv_en = 1; line_rx = 1; n = cyc;
    expect_at(n + DET - 1, 9'h100, WKI, "R2 no wake before window");
    expect_at(n + DET, 9'h0C0, WKI, "R2 wake after window, R5 irq");
    expect_at(n + DET + PUL - 1, 9'h0C0, WKI, "R3 pulse still low");
    expect_at(n + DET + PUL, 9'h1C0, WKI, "R3 pulse ended, R5 flag held");
    expect_at(n + DET + PUL + 10, 9'h1C0, WKI, "R2 single event per mismatch");
    drain();
    line_rx = 0;

    // R5: mask and clear
    step(1); wake_mask = 1; expect_at(cyc, 9'h180, WKI, "R5 irq masked");
    step(1); wake_mask = 0; expect_at(cyc, 9'h1C0, WKI, "R5 irq unmasked");
    step(1); int_read = 1; expect_at(cyc, 9'h1C0, WKI, "R5 flag before read");
    step(1); int_read = 0; expect_at(cyc, 9'h100, WKI, "R5 flag cleared by read");
    drain();

    // R2: short mismatch ignored
    line_rx = 1; n = cyc;
    step(DET - 1); line_rx = 0;
    expect_at(n + DET + 2, 9'h100, WK, "R2 short mismatch ignored");
    drain();

    // R4: detection disabled
    detect_off = 1; line_rx = 1; n = cyc;
    expect_at(n + DET + 4, 9'h100, WK, "R4 disabled detect");
    drain();
    line_rx = 0; step(1); detect_off = 0; step(2);

    // R6: blanking with two selections
    blank_sel = 1; drv_level = 1; n = cyc;
    expect_at(n + B1 + DET, 9'h100, WK, "R6 blanked window sel1");
    expect_at(n + 1 + B1 + DET, 9'h080, WK, "R6 wake after blank sel1");
    drain(); step(PUL);
    drv_level = 0; step(1); int_read = 1; step(1); int_read = 0; step(B3 + 2);
    blank_sel = 3; drv_level = 1; n = cyc;
    expect_at(n + B3 + DET, 9'h100, WK, "R6 blanked window sel3");
    expect_at(n + 1 + B3 + DET, 9'h080, WK, "R6 wake after blank sel3");
    drain(); step(PUL);
    drv_level = 0; step(1); int_read = 1; step(1); int_read = 0; step(B3 + 2);
    blank_sel = 0; drv_level = 1; n = cyc;
    step(B0); line_rx = 1;
    expect_at(n + B0 + DET + 3, 9'h100, WK, "R6 lagging line inside blank ignored");
    drain();
    drv_en = 0; drv_level = 0; line_rx = 0; step(B3 + 2);

    // R7: start rejected
    tx_en_pin = 1; tx_pin = 1; gen_start = 1; step(1); gen_start = 0;
    expect_at(cyc, 9'h000, OVR, "R7 rejected with tx enable high");
    drain();
    tx_en_pin = 0; tx_pin = 0; gen_start = 1; step(1); gen_start = 0;
    expect_at(cyc, 9'h000, OVR, "R7 rejected with tx low");
    drain();

    // R8/R9/R10: generation from line high, with mismatch present
    tx_pin = 1; line_rx = 1; drv_en = 1; gen_start = 1; n = cyc;
    expect_at(n, 9'h000, OVR, "R9 idle overrides");
    expect_at(n + 1, 9'h027, OVR, "R8 opposite phase start");
    expect_at(n + GEN, 9'h027, OVR, "R8 opposite phase end");
    expect_at(n + GEN + 1, 9'h037, OVR, "R8 drive-back phase");
    expect_at(n + GEN + ON, 9'h037, OVR, "R8 drive-back end");
    expect_at(n + GEN + ON + 1, 9'h00F, OVR, "R8 hiz phase");
    expect_at(n + GEN + ON + HIZ, 9'h00F, OVR, "R8 hiz ignores tx pins");
    expect_at(n + GEN + ON + HIZ + 1, 9'h000, OVR, "R9 overrides dropped");
    expect_at(n + GEN + ON + HIZ + 3, 9'h100, WK, "R10 no detect while busy");
    step(1); gen_start = 0;
    step(2); gen_start = 1; step(1); gen_start = 0;
    step(GEN + ON - 3); tx_en_pin = 1; tx_pin = 0;
    step(HIZ - 3); line_rx = 0;
    drain();
    tx_en_pin = 0; tx_pin = 1; drv_en = 0; step(2);

    // R8: generation from line low
    gen_start = 1; n = cyc;
    expect_at(n + 1, 9'h037, OVR, "R8 opposite is high");
    expect_at(n + GEN + 1, 9'h027, OVR, "R8 back to low");
    expect_at(n + GEN + ON + HIZ + 1, 9'h000, OVR, "R8 idle again");
    step(1); gen_start = 0;
    drain();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule